// File: doc/BRIEF.md
# Configurable synchronous serial transceiver

A full-duplex shift engine for a four-wire clocked serial link of the SPI family. One word of 2 to 16 bits is shifted out on the serial output while a word of the same length is shifted in from the serial input. Word length, bit order, clock phase, clock polarity, internal loopback and master or slave role all come from a control word. In master mode the block makes the shift clock from a programmable divider and drives it out. In slave mode it shifts on a clock that arrives from outside.

The control word and the divider can be changed only while the unit is disabled. Once it is enabled, a write to the control word updates only the enable and master bits. Software loads a word into the transmit buffer. In master mode that load, made while enabled and idle, starts the transfer. In slave mode the first leading edge of the external clock starts it. When the word is done, the received word goes to the receive buffer and a strobe lasting one cycle is raised.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset the unit is disabled and idle. `busy`, `rx_done`, `bit_cnt`, `rx_data`, `ser_out`, `sclk_out` and `sclk_oe` are all 0.
- R2: The control word holds a 4-bit length field in bits [3:0]. The word length is that field plus one. A field value of 0 is treated as 1, giving 2-bit words.
- R3: Control bit 4 selects bit order. At 0 the least significant bit goes first and at 1 the most significant bit goes first. The same order applies to transmit and receive. `rx_data` holds the word right-aligned with its upper bits cleared.
- R4: Control bit 5 selects clock phase. At 0 the first bit is on `ser_out` before the first leading edge, input is sampled on leading edges, and output advances on trailing edges. At 1 output advances on leading edges after the first, and input is sampled on trailing edges.
- R5: Control bit 6 selects clock polarity. At 0 the clock idles low and leading edges rise. At 1 it idles high and leading edges fall.
- R6: With control bit 7 set, receive data is taken from the unit's own serial output, and `ser_in` is ignored.
- R7: With control bit 8 set (master), `sclk_oe` is 1. `sclk_out` toggles every reload+1 clock cycles during a transfer, where reload is the 16-bit divider value. The first toggle comes reload+1 cycles after the cycle in which the load is accepted.
- R8: With control bit 8 clear (slave), `sclk_oe` is 0. The unit shifts on edges of `sclk_in` after synchronizing them, and the first leading edge starts the transfer.
- R9: Control bit 9 enables the unit. While enabled, control writes change only bits 8 and 9, and divider writes are ignored. While disabled, buffer loads start nothing.
- R10: `busy` is high from the start of a transfer until its last trailing edge. `bit_cnt` gives the number of bits already completed in the current word.
- R11: On the last trailing edge of a word, `busy` falls, `rx_data` takes the received word, and `rx_done` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 10 | Control word: [3:0] length-1, [4] MSB first, [5] phase, [6] polarity, [7] loopback, [8] master, [9] enable |
| baud_wr | input | 1 | Divider write strobe |
| baud_wdata | input | BAUD_W | Divider reload value |
| tx_wr | input | 1 | Transmit buffer load strobe |
| tx_wdata | input | 16 | Transmit word, right-aligned |
| rx_data | output | 16 | Receive buffer, right-aligned |
| rx_done | output | 1 | One-cycle word-complete strobe |
| busy | output | 1 | Transfer in progress |
| bit_cnt | output | 4 | Bits completed in the current word |
| sclk_in | input | 1 | Shift clock from the link (slave) |
| sclk_out | output | 1 | Generated shift clock (master) |
| sclk_oe | output | 1 | Drive enable for the shift clock |
| ser_out | output | 1 | Serial data out |
| ser_in | input | 1 | Serial data in |

## Verification
Master transfers are tried at the shortest, a middle and the longest word length, at both bit orders, at all four phase and polarity pairs, and with divider values from 0 to 3. A behavioural model predicts `sclk_out`, `ser_out`, `busy`, `bit_cnt` and `rx_done` on every clock, so an off-by-one in the divider, a swapped phase or a reversed order each shows up as a mismatch in a specific cycle. A loopback run drives the inverse of the transmitted bits on `ser_in`, so any leak from the pin corrupts `rx_data`. Slave runs at two phase and polarity settings separate edge-detection faults from shift faults. A lock run writes a different control word and divider while the unit is enabled, then checks that the clock level and the transfer length are those of the earlier configuration.

// File: rtl/sxc_pkg.sv
package sxc_pkg;
    localparam int SXC_DW = 16;
    localparam int SXC_WF = $clog2(SXC_DW);

    typedef struct packed {
        logic              enable;
        logic              master;
        logic              loopback;
        logic              cpol;
        logic              cpha;
        logic              msb_first;
        logic [SXC_WF-1:0] len_m1;
    } sxc_cfg_t;

    typedef struct packed {
        logic              busy;
        logic              sclk;
        logic              done;
        logic [SXC_WF-1:0] cnt;
        logic [SXC_WF-1:0] txc;
        logic [SXC_DW-1:0] txw;
        logic [SXC_DW-1:0] rxw;
        logic [SXC_DW-1:0] rxb;
    } sxc_state_t;

    function automatic logic [SXC_WF:0] sxc_word_len(input logic [SXC_WF-1:0] f);
        return (f == '0) ? (SXC_WF+1)'(2) : ({1'b0, f} + 1'b1);
    endfunction
endpackage

// File: rtl/sxc_baud.sv
module sxc_baud #(
    parameter int BW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          restart,
    input  logic [BW-1:0] reload,
    output logic          tick
);
    logic [BW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = run && (cnt_q == '0);
        if (restart)     cnt_d = reload;
        else if (run)    cnt_d = (cnt_q == '0) ? reload : cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R7
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && reload != '0 && $stable(reload)) |=> !tick);
endmodule

// File: rtl/sxc_edge.sv
module sxc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic cpol,
    output logic edge_o,
    output logic lead_o
);
    logic [2:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[1:0], sclk_in};
        edge_o = sync_q[2] ^ sync_q[1];
        lead_o = (sync_q[2] == cpol);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end
endmodule

// File: rtl/sxc_shifter.sv
module sxc_shifter
    import sxc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  sxc_cfg_t          cfg,
    input  logic              load,
    input  logic              start,
    input  logic [SXC_DW-1:0] tx_wdata,
    input  logic              tick,
    input  logic              s_edge,
    input  logic              s_lead,
    input  logic              ser_in,
    output logic              ser_out,
    output logic              sclk,
    output logic              busy,
    output logic              done,
    output logic [SXC_WF-1:0] cnt,
    output logic [SXC_DW-1:0] rx_word
);
    localparam int DW = SXC_DW;
    localparam int CW = SXC_WF;
    localparam int WW = SXC_WF + 1;

    sxc_state_t st_d, st_q;
    logic [WW-1:0] wlen;
    logic [CW-1:0] last_idx, cnt_pos;
    logic [DW-1:0] len_mask;
    logic          edge_any, lead_any, edge_ok, rx_bit;

    function automatic logic [CW-1:0] bit_pos(input logic [CW-1:0] i,
                                              input logic [WW-1:0] w,
                                              input logic msb);
        return msb ? CW'(w - WW'(1) - WW'(i)) : i;
    endfunction

    always_comb begin
        wlen     = sxc_word_len(cfg.len_m1);
        last_idx = CW'(wlen - WW'(1));
        for (int b = 0; b < DW; b++) len_mask[b] = (b < int'(wlen));
        cnt_pos  = bit_pos(st_q.cnt, wlen, cfg.msb_first);
        ser_out  = st_q.txw[bit_pos(st_q.txc, wlen, cfg.msb_first)];
        rx_bit   = cfg.loopback ? ser_out : ser_in;
        edge_any = cfg.master ? (st_q.busy && tick) : s_edge;
        lead_any = cfg.master ? (st_q.sclk == cfg.cpol) : s_lead;
        edge_ok  = edge_any && (st_q.busy || (!cfg.master && lead_any));

        st_d      = st_q;
        st_d.done = 1'b0;
        if (!cfg.enable) begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
            st_d.txc  = '0;
            st_d.sclk = cfg.cpol;
        end else begin
            if (!st_q.busy) begin
                st_d.sclk = cfg.cpol;
                if (load)  st_d.txw  = tx_wdata;
                if (start) st_d.busy = 1'b1;
            end
            if (edge_ok) begin
                st_d.busy = 1'b1;
                if (cfg.master) st_d.sclk = ~st_q.sclk;
                if (lead_any) begin
                    if (!cfg.cpha) st_d.rxw[cnt_pos] = rx_bit;
                    else           st_d.txc = st_q.cnt;
                end else begin
                    if (cfg.cpha) st_d.rxw[cnt_pos] = rx_bit;
                    if (st_q.cnt == last_idx) begin
                        st_d.busy = 1'b0;
                        st_d.cnt  = '0;
                        st_d.txc  = '0;
                        st_d.done = 1'b1;
                        st_d.rxb  = st_d.rxw & len_mask;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                        if (!cfg.cpha) st_d.txc = st_q.cnt + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sclk    = st_q.sclk;
    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign cnt     = st_q.cnt;
    assign rx_word = st_q.rxb;

    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        WW'(st_q.cnt) < wlen);
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);
    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> (!st_q.busy && st_q.cnt == '0));
    // R5
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && $past(!st_q.busy) && $stable(cfg)) |-> (st_q.sclk == cfg.cpol));
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
    import sxc_pkg::*;
#(
    parameter int BAUD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [9:0]          cfg_wdata,
    input  logic                baud_wr,
    input  logic [BAUD_W-1:0]   baud_wdata,
    input  logic                tx_wr,
    input  logic [SXC_DW-1:0]   tx_wdata,
    output logic [SXC_DW-1:0]   rx_data,
    output logic                rx_done,
    output logic                busy,
    output logic [SXC_WF-1:0]   bit_cnt,
    input  logic                sclk_in,
    output logic                sclk_out,
    output logic                sclk_oe,
    output logic                ser_out,
    input  logic                ser_in
);
    sxc_cfg_t          cfg_d, cfg_q, cfg_new;
    logic [BAUD_W-1:0] baud_d, baud_q;
    logic              tx_take, m_start, tick, s_edge, s_lead;

    always_comb begin
        cfg_new = sxc_cfg_t'(cfg_wdata);
        cfg_d   = cfg_q;
        baud_d  = baud_q;
        if (cfg_wr) begin
            if (!cfg_q.enable) begin
                cfg_d = cfg_new;
            end else begin
                cfg_d.enable = cfg_new.enable;
                cfg_d.master = cfg_new.master;
            end
        end
        if (baud_wr && !cfg_q.enable) baud_d = baud_wdata;
        tx_take = tx_wr && cfg_q.enable && !busy;
        m_start = tx_take && cfg_q.master;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            baud_q <= '0;
        end else begin
            cfg_q  <= cfg_d;
            baud_q <= baud_d;
        end
    end

    sxc_baud #(.BW(BAUD_W)) i_baud (
        .clk(clk), .rst_n(rst_n),
        .run(busy && cfg_q.master && cfg_q.enable),
        .restart(m_start), .reload(baud_q), .tick(tick)
    );

    sxc_edge i_edge (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .cpol(cfg_q.cpol),
        .edge_o(s_edge), .lead_o(s_lead)
    );

    sxc_shifter i_shift (
        .clk(clk), .rst_n(rst_n), .cfg(cfg_q),
        .load(tx_take), .start(m_start), .tx_wdata(tx_wdata),
        .tick(tick), .s_edge(s_edge), .s_lead(s_lead), .ser_in(ser_in),
        .ser_out(ser_out), .sclk(sclk_out), .busy(busy), .done(rx_done),
        .cnt(bit_cnt), .rx_word(rx_data)
    );

    assign sclk_oe = cfg_q.master && cfg_q.enable;

    // R9
    cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.enable |=> (cfg_q[7:0] == $past(cfg_q[7:0])));
    // R9
    baud_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.enable |=> (baud_q == $past(baud_q)));
endmodule

// File: tb/test_sync_serial_xcvr.sv
`timescale 1ns/1ps
module test_sync_serial_xcvr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [9:0]  cfg_wdata = '0;
    logic        baud_wr = 1'b0;
    logic [15:0] baud_wdata = '0;
    logic        tx_wr = 1'b0;
    logic [15:0] tx_wdata = '0;
    logic [15:0] rx_data;
    logic        rx_done, busy, sclk_out, sclk_oe, ser_out;
    logic [3:0]  bit_cnt;
    logic        sclk_in = 1'b0;
    logic        ser_in = 1'b0;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sync_serial_xcvr i_sync_serial_xcvr (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .baud_wr(baud_wr), .baud_wdata(baud_wdata), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
        .rx_data(rx_data), .rx_done(rx_done), .busy(busy), .bit_cnt(bit_cnt),
        .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
        .ser_out(ser_out), .ser_in(ser_in)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int wlen(input int f);
        return (f == 0) ? 2 : f + 1;
    endfunction

    function automatic logic bsel(input int word, input int j, input int w, input bit msb);
        return msb ? word[w-1-j] : word[j];
    endfunction

    function automatic int lmask(input int w);
        return (1 << w) - 1;
    endfunction

    function automatic logic [9:0] cfgv(input bit en, input bit ms, input bit lb, input bit po,
                                        input bit ph, input bit msb, input int f);
        return {en, ms, lb, po, ph, msb, 4'(f)};
    endfunction

    task automatic cfg_write(input logic [9:0] v);
        @(negedge clk); cfg_wdata = v; cfg_wr = 1'b1;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic baud_write(input int v);
        @(negedge clk); baud_wdata = 16'(v); baud_wr = 1'b1;
        @(negedge clk); baud_wr = 1'b0;
    endtask

    task automatic master_setup(input int f, input bit msb, input bit ph, input bit po,
                                input bit lb, input int rl);
        cfg_write(10'h0);
        baud_write(rl);
        cfg_write(cfgv(1, 1, lb, po, ph, msb, f));
        repeat (3) @(negedge clk);
    endtask

    // Behavioural model: after n edges since the accepting edge, the clock has toggled n/(rl+1) times.
    task automatic master_run(input string tag, input int f, input bit msb, input bit ph, input bit po,
                              input bit lb, input int rl, input int txw, input int slw);
        int w = wlen(f);
        int tn = 2 * w * (rl + 1);
        int dones = 0;
        @(negedge clk);
        tx_wdata = 16'(txw); tx_wr = 1'b1;
        ser_in = lb ? ~bsel(txw, 0, w, msb) : bsel(slw, 0, w, msb);
        @(posedge clk); @(negedge clk); tx_wr = 1'b0;
        chk(tag, "R7 sclk_oe in master", 32'(sclk_oe), 1);
        for (int n = 0; n <= tn + 2; n++) begin
            int t = n / (rl + 1);
            int idx;
            if (t > 2 * w) t = 2 * w;
            if (t >= 2 * w)  idx = 0;
            else if (!ph)    idx = t / 2;
            else             idx = (t == 0) ? 0 : (t - 1) / 2;
            chk(tag, "R5 R7 sclk_out", 32'(sclk_out), 32'(po ^ t[0]));
            chk(tag, "R10 busy", 32'(busy), 32'(n < tn));
            chk(tag, "R10 bit_cnt", 32'(bit_cnt), (t >= 2 * w) ? 0 : t / 2);
            chk(tag, "R3 R4 ser_out", 32'(ser_out), 32'(bsel(txw, idx, w, msb)));
            chk(tag, "R11 rx_done", 32'(rx_done), 32'(n == tn));
            if (rx_done) dones++;
            ser_in = lb ? ~bsel(txw, idx, w, msb) : bsel(slw, idx, w, msb);
            @(posedge clk); @(negedge clk);
        end
        chk(tag, "R11 single done pulse", dones, 1);
        chk(tag, "R2 R3 R6 rx_data", 32'(rx_data), lb ? (txw & lmask(w)) : (slw & lmask(w)));
    endtask

    task automatic slave_run(input string tag, input int f, input bit msb, input bit ph, input bit po,
                             input int txw, input int mw);
        int w = wlen(f);
        int got = 0;
        int exp_seq = 0;
        cfg_write(10'h0);
        sclk_in = po;
        cfg_write(cfgv(1, 0, 0, po, ph, msb, f));
        repeat (4) @(negedge clk);
        tx_wdata = 16'(txw); tx_wr = 1'b1;
        @(negedge clk); tx_wr = 1'b0;
        chk(tag, "R8 sclk_oe in slave", 32'(sclk_oe), 0);
        chk(tag, "R8 idle before first edge", 32'(busy), 0);
        for (int j = 0; j < w; j++) begin
            exp_seq[j] = bsel(txw, j, w, msb);
            if (!ph) begin
                ser_in = bsel(mw, j, w, msb);
                repeat (8) @(negedge clk);
                got[j] = ser_out;
                sclk_in = ~po;
                repeat (8) @(negedge clk);
                if (j == 0) chk(tag, "R8 R10 busy after leading edge", 32'(busy), 1);
                sclk_in = po;
            end else begin
                sclk_in = ~po;
                ser_in = bsel(mw, j, w, msb);
                repeat (8) @(negedge clk);
                got[j] = ser_out;
                if (j == 0) chk(tag, "R8 R10 busy after leading edge", 32'(busy), 1);
                sclk_in = po;
                repeat (8) @(negedge clk);
            end
        end
        repeat (6) @(negedge clk);
        chk(tag, "R8 R3 R4 bits sent", got, exp_seq);
        chk(tag, "R8 R2 rx_data", 32'(rx_data), mw & lmask(w));
        chk(tag, "R10 busy after word", 32'(busy), 0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R10: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "busy", 32'(busy), 0);
        chk("R1", "rx_done", 32'(rx_done), 0);
        chk("R1", "bit_cnt", 32'(bit_cnt), 0);
        chk("R1", "rx_data", 32'(rx_data), 0);
        chk("R1", "ser_out", 32'(ser_out), 0);
        chk("R1", "sclk_out", 32'(sclk_out), 0);
        chk("R1", "sclk_oe", 32'(sclk_oe), 0);

        // R2 R3 R4 R5: 8 bits, LSB first, phase 0, polarity 0
        master_setup(7, 0, 0, 0, 0, 1);
        master_run("R3", 7, 0, 0, 0, 0, 1, 32'h0A5, 32'h03C);
        // R4 R5: 16 bits, MSB first, phase 1, polarity 1
        master_setup(15, 1, 1, 1, 0, 2);
        master_run("R4", 15, 1, 1, 1, 0, 2, 32'hBEEF, 32'h1234);
        // R2: field 0 gives 2 bits, divider 0
        master_setup(0, 1, 0, 1, 0, 0);
        master_run("R2", 0, 1, 0, 1, 0, 0, 32'hFFF2, 32'h0001);
        // R6: loopback, ser_in driven with inverted data
        master_setup(11, 0, 1, 0, 1, 3);
        master_run("R6", 11, 0, 1, 0, 1, 3, 32'h0ABC, 32'h0000);
        // R7: 5 bits, divider 0, phase 1 polarity 0
        master_setup(4, 1, 1, 0, 0, 0);
        master_run("R7", 4, 1, 1, 0, 0, 0, 32'h0013, 32'h000E);

        // R8 slave mode
        slave_run("R8", 7, 1, 0, 0, 32'h00C5, 32'h005A);
        slave_run("R8", 9, 0, 1, 1, 32'h0321, 32'h02A7);

        // R9: writes while enabled must not change length, polarity or divider
        master_setup(7, 0, 0, 0, 0, 1);
        cfg_write(cfgv(1, 1, 1, 1, 1, 1, 3));
        baud_write(5);
        repeat (3) @(negedge clk);
        chk("R9", "sclk_out keeps old polarity", 32'(sclk_out), 0);
        master_run("R9", 7, 0, 0, 0, 0, 1, 32'h0081, 32'h007E);
        // R9: buffer load while disabled starts nothing
        cfg_write(10'h0);
        @(negedge clk); tx_wdata = 16'h5555; tx_wr = 1'b1;
        @(negedge clk); tx_wr = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk("R9", "busy while disabled", 32'(busy), 0);
            chk("R9", "sclk_oe while disabled", 32'(sclk_oe), 0);
            @(negedge clk);
        end
        finish_run();
    end
endmodule